// File: doc/BRIEF.md
# Six-Step Three-Phase Bridge Gate Sequencer

This block drives the six gate signals of a three-phase half-bridge inverter through a six-step commutation cycle. A modulo-6 state counter moves forward by one state on each clock edge at which the step enable is high. A one-hot decoder with active-low lines turns the count into state lines. Gate-map logic then combines those lines into the high-side and low-side gate demands of each leg. A registered dead-time stage, one per leg, forms the gate outputs.

Two conduction patterns can be selected. In the 180-degree pattern each leg behaves as a complementary pair, and a programmable dead time keeps both switches of a leg off around every change of its high-side demand. In the 120-degree pattern exactly two switches conduct in every state, one high-side and one low-side in different legs, so no dead time is needed. The selected pattern is only adopted when the counter wraps from state 5 to state 0. A PWM chop input gates the high-side outputs combinationally, so the output voltage can be varied while the low-side switches conduct for their whole states.

Leg indices 0, 1 and 2 stand for phases A, B and C. The mode select is 0 for the 180-degree pattern and 1 for the 120-degree pattern. All pins are plain control pins and have no handshake.

Top module: `sixstep_gate_seq`

## Requirements
- R1: `state` shows the count. The count goes 0,1,2,3,4,5,0,… and advances by one on each rising clock edge where `step_en` is 1. It holds when `step_en` is 0.
- R2: While `rst` is sampled high at a clock edge, `state` becomes 0, all six gates are off, and the active mode is loaded from `mode_sel`.
- R3: In the 180-degree mode (active mode 0), the high-side demand is set in states {0,4,5} for leg 0, {0,1,2} for leg 1 and {2,3,4} for leg 2. The low-side demand is its complement. Outside dead time, each gate equals its demand for the state shown one cycle earlier. A leg never has both gates on.
- R4: In the 180-degree mode, when the high-side demand of a leg differs from the one the dead-time stage last saw, both gates of that leg are off for exactly DEAD cycles. This starts one cycle after `state` shows the new state. The leg then takes its new levels. Legs whose demand is unchanged are not affected.
- R5: In the 120-degree mode (active mode 1), the high-side gates are on for leg 0 in {0,1}, leg 1 in {2,3} and leg 2 in {4,5}. The low-side gates are on for leg 0 in {3,4}, leg 1 in {0,5} and leg 2 in {1,2}. The gates follow `state` with one cycle of latency and have no dead time.
- R6: In the 120-degree mode, with `pwm_in` high, exactly two of the six gates are on, one high-side and one low-side, in different legs.
- R7: `gate_hi` is the registered high-side level ANDed with `pwm_in` in the same cycle. `gate_lo` is not affected by `pwm_in`.
- R8: A change on `mode_sel` takes effect only when a step moves the count from 5 to 0, or at reset. The gates produced for that state 0 already follow the new mode.
- R9: `state` never shows 6 or 7. An out-of-range count forces all gates off and returns the count to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the commutation state on this edge |
| mode_sel | input | 1 | Requested pattern: 0 = 180-degree, 1 = 120-degree |
| pwm_in | input | 1 | PWM chop applied to high-side gates |
| gate_hi | output | 3 | High-side gates, bit i = leg i |
| gate_lo | output | 3 | Low-side gates, bit i = leg i |
| state | output | 3 | Current commutation state, 0 to 5 |

## Verification
A counter that skips, repeats or wraps wrongly shows up on `state` on the very next edge, and it moves the gate pattern one cycle later. A dead-time counter loaded with the wrong value, or decremented wrongly, shows up as a leg whose gates come back on a cycle early or late after its first step. A mode register that loads outside the 5-to-0 wrap shows up in the first gate pattern after `mode_sel` changes, which then does not match the old mode's table. A chop or map fault shows up in the same cycle as a gate that differs from its table entry.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;
  localparam int NUM_STATES = 6;
  localparam int CNT_W      = 3;
  localparam int NUM_LEGS   = 3;
  localparam int NUM_LINES  = 1 << CNT_W;

  typedef enum logic {
    MODE_180 = 1'b0,
    MODE_120 = 1'b1
  } mode_e;

  // state-membership mask, bit s set when the gate is demanded in state s
  function automatic logic [NUM_STATES-1:0] gate_mask(mode_e m, int leg, logic top);
    logic [NUM_STATES-1:0] t180;
    logic [NUM_STATES-1:0] t120;
    logic [NUM_STATES-1:0] b120;
    case (leg)
      0:       begin t180 = 6'b110001; t120 = 6'b000011; b120 = 6'b011000; end
      1:       begin t180 = 6'b000111; t120 = 6'b001100; b120 = 6'b100001; end
      default: begin t180 = 6'b011100; t120 = 6'b110000; b120 = 6'b000110; end
    endcase
    if (m == MODE_180) return top ? t180 : ~t180;
    return top ? t120 : b120;
  endfunction
endpackage

// File: rtl/sixstep_counter.sv
module sixstep_counter
  import sixstep_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_STATES - 1);

  logic at_last;
  logic illegal;

  assign at_last = (cnt == LAST);
  assign illegal = (cnt > LAST);

  always_ff @(posedge clk) begin
    if (rst || illegal) begin
      cnt <= '0;
    end else if (step_en) begin
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end

  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !illegal) |=> $stable(cnt));
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (step_en && at_last) |=> (cnt == '0));
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (step_en && !at_last && !illegal) |=> (cnt == $past(cnt) + 1'b1));
  a_r9_recover: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (cnt == '0));
endmodule

// File: rtl/sixstep_decoder.sv
module sixstep_decoder
  import sixstep_pkg::*;
(
  input  logic [CNT_W-1:0]     cnt,
  output logic [NUM_LINES-1:0] line_n
);
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    assign line_n[k] = (cnt != CNT_W'(k));
  end

  always_comb begin
    a_r9_onehot: assert ($countones(~line_n) == 1);
  end
endmodule

// File: rtl/sixstep_gate_map.sv
module sixstep_gate_map
  import sixstep_pkg::*;
(
  input  logic [NUM_LINES-1:0] line_n,
  input  mode_e                mode,
  output logic [NUM_LEGS-1:0]  want_hi,
  output logic [NUM_LEGS-1:0]  want_lo
);
  logic legal;
  assign legal = &line_n[NUM_LINES-1:NUM_STATES];

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    logic [NUM_STATES-1:0] m_hi;
    logic [NUM_STATES-1:0] m_lo;
    assign m_hi = gate_mask(mode, g, 1'b1);
    assign m_lo = gate_mask(mode, g, 1'b0);
    // OR of selected states built as NAND of the active-low lines
    assign want_hi[g] = legal & ~(&(line_n[NUM_STATES-1:0] | ~m_hi));
    assign want_lo[g] = legal & ~(&(line_n[NUM_STATES-1:0] | ~m_lo));
  end

  always_comb begin
    a_r9_illegal_off: assert (legal || (want_hi == '0 && want_lo == '0));
  end
endmodule

// File: rtl/sixstep_leg_dt.sv
module sixstep_leg_dt
  import sixstep_pkg::*;
#(
  parameter int DEAD = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode,
  input  logic  want_hi,
  input  logic  want_lo,
  output logic  hi_en,
  output logic  lo_en
);
  localparam int DT_W = (DEAD > 0) ? $clog2(DEAD + 1) : 1;
  localparam logic [DT_W-1:0] DT_LOAD = DT_W'(DEAD);

  logic            prev_hi;
  logic [DT_W-1:0] dcnt;
  logic [DT_W-1:0] dnext;
  logic            edge_seen;

  assign edge_seen = (mode == MODE_180) && (want_hi != prev_hi);

  always_comb begin
    if (mode == MODE_120)   dnext = '0;
    else if (edge_seen)     dnext = DT_LOAD;
    else if (dcnt != '0)    dnext = dcnt - 1'b1;
    else                    dnext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_hi <= 1'b0;
      dcnt    <= '0;
      hi_en   <= 1'b0;
      lo_en   <= 1'b0;
    end else begin
      prev_hi <= want_hi;
      dcnt    <= dnext;
      hi_en   <= (dnext == '0) & want_hi;
      lo_en   <= (dnext == '0) & want_lo;
    end
  end

  a_r3_no_shoot: assert property (@(posedge clk) disable iff (rst)
    !(hi_en && lo_en));
  a_r4_dead_off: assert property (@(posedge clk) disable iff (rst)
    (dcnt != '0) |-> (!hi_en && !lo_en));
  if (DEAD > 0) begin : g_dt_chk
    a_r4_dead_start: assert property (@(posedge clk) disable iff (rst)
      edge_seen |=> (!hi_en && !lo_en));
  end
endmodule

// File: rtl/sixstep_gate_seq.sv
module sixstep_gate_seq
  import sixstep_pkg::*;
#(
  parameter int DEAD = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_en,
  input  logic                mode_sel,
  input  logic                pwm_in,
  output logic [NUM_LEGS-1:0] gate_hi,
  output logic [NUM_LEGS-1:0] gate_lo,
  output logic [CNT_W-1:0]    state
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_STATES - 1);

  logic [CNT_W-1:0]     cnt;
  logic [NUM_LINES-1:0] line_n;
  logic [NUM_LEGS-1:0]  want_hi;
  logic [NUM_LEGS-1:0]  want_lo;
  logic [NUM_LEGS-1:0]  hi_en;
  logic [NUM_LEGS-1:0]  lo_en;
  logic                 boundary;
  mode_e                mode_q;

  assign boundary = (step_en && cnt == LAST) || (cnt > LAST);

  always_ff @(posedge clk) begin
    if (rst || boundary) mode_q <= mode_e'(mode_sel);
  end

  sixstep_counter i_cnt (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .cnt     (cnt)
  );

  sixstep_decoder i_dec (
    .cnt    (cnt),
    .line_n (line_n)
  );

  sixstep_gate_map i_map (
    .line_n  (line_n),
    .mode    (mode_q),
    .want_hi (want_hi),
    .want_lo (want_lo)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    sixstep_leg_dt #(.DEAD(DEAD)) i_leg (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode_q),
      .want_hi (want_hi[g]),
      .want_lo (want_lo[g]),
      .hi_en   (hi_en[g]),
      .lo_en   (lo_en[g])
    );
  end

  assign gate_hi = hi_en & {NUM_LEGS{pwm_in}};
  assign gate_lo = lo_en;
  assign state   = cnt;

  a_r2_reset_off: assert property (@(posedge clk)
    rst |=> (hi_en == '0 && lo_en == '0 && cnt == '0));
  a_r6_two_on: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_120 && cnt <= LAST) |=>
      ($countones(hi_en) == 1 && $countones(lo_en) == 1 && (hi_en & lo_en) == '0));
  a_r7_chop: assert property (@(posedge clk) disable iff (rst)
    !pwm_in |-> (gate_hi == '0 && gate_lo == lo_en));
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(mode_q));
  a_r9_range: assert property (@(posedge clk) disable iff (rst)
    state <= LAST);
endmodule

// File: tb/test_sixstep_gate_seq.sv
module test_sixstep_gate_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_en = 1'b0;
  logic mode_sel = 1'b0;
  logic pwm_in = 1'b1;
  logic [2:0] gate_hi, gate_lo, state;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0;
  bit m_mode = 0;
  bit m_gmode = 0;
  bit m_mode_new = 0;
  bit m_dead = 0;
  bit m_prev[3];
  int m_d[3];
  bit m_hi[3];
  bit m_lo[3];

  sixstep_gate_seq #(.DEAD(DEAD)) i_sixstep_gate_seq (
    .clk(clk), .rst(rst), .step_en(step_en), .mode_sel(mode_sel),
    .pwm_in(pwm_in), .gate_hi(gate_hi), .gate_lo(gate_lo), .state(state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit top180(int leg, int s);
    case (leg)
      0: return s == 0 || s == 4 || s == 5;
      1: return s <= 2;
      default: return s >= 2 && s <= 4;
    endcase
  endfunction

  function automatic bit top120(int leg, int s);
    return s / 2 == leg;
  endfunction

  function automatic bit bot120(int leg, int s);
    case (leg)
      0: return s == 3 || s == 4;
      1: return s == 0 || s == 5;
      default: return s == 1 || s == 2;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(bit r, bit se, bit ms);
    bit wt, wb, chg;
    int nd;
    if (r) begin
      m_cnt = 0; m_mode = ms; m_gmode = ms; m_mode_new = 0; m_dead = 0;
      for (int l = 0; l < 3; l++) begin
        m_prev[l] = 0; m_d[l] = 0; m_hi[l] = 0; m_lo[l] = 0;
      end
      return;
    end
    m_gmode = m_mode;
    m_dead = 0;
    for (int l = 0; l < 3; l++) begin
      wt = m_mode ? top120(l, m_cnt) : top180(l, m_cnt);
      wb = m_mode ? bot120(l, m_cnt) : !wt;
      chg = !m_mode && (wt != m_prev[l]);
      if (m_mode) nd = 0;
      else if (chg) nd = DEAD;
      else nd = (m_d[l] > 0) ? m_d[l] - 1 : 0;
      if (chg || m_d[l] > 0) m_dead = 1;
      m_d[l] = nd;
      m_prev[l] = wt;
      m_hi[l] = (nd == 0) && wt;
      m_lo[l] = (nd == 0) && wb;
    end
    m_mode_new = 0;
    if (se) begin
      if (m_cnt == 5) begin
        m_mode_new = (m_mode != ms);
        m_mode = ms;
      end
      m_cnt = (m_cnt + 1) % 6;
    end
  endtask

  // one clock: drive at falling edge, update model at rising edge, compare after
  task automatic cyc(bit r, bit se, bit ms, bit pw);
    bit was_new;
    int ehi, elo;
    string tag;
    @(negedge clk);
    rst = r; step_en = se; mode_sel = ms; pwm_in = pw;
    was_new = m_mode_new;
    @(posedge clk);
    model_edge(r, se, ms);
    #1;
    ehi = 0; elo = 0;
    for (int l = 0; l < 3; l++) begin
      ehi |= int'(m_hi[l] && pw) << l;
      elo |= int'(m_lo[l]) << l;
    end
    if (r) begin
      check("R2 state", state, 0);
      check("R2 gate_hi", gate_hi, 0);
      check("R2 gate_lo", gate_lo, 0);
      return;
    end
    check("R1 state", state, m_cnt);
    check("R9 range", int'(state <= 3'd5), 1);
    if (was_new) tag = "R8";
    else if (m_gmode) tag = "R5";
    else if (m_dead) tag = "R4";
    else tag = "R3";
    check({tag, " gate_hi"}, gate_hi, ehi);
    check({tag, " gate_lo"}, gate_lo, elo);
    if (!pw) check("R7 chop", gate_hi, 0);
    if (m_gmode && pw)
      check("R6 two_on", $countones({gate_hi, gate_lo}), 2);
    if (!m_gmode)
      check("R3 no_shoot", int'((gate_hi & gate_lo) == 3'b000), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reset in 180-degree mode
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1);
    // slow steps: dead time completes each state (R3, R4)
    for (int i = 0; i < 48; i++) cyc(0, (i % 6) == 5, 0, 1);
    // step every cycle: dead time retriggers
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 1);
    // hold (R1)
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1);
    // request 120 mode mid-cycle; applied only at wrap (R8)
    for (int i = 0; i < 60; i++) cyc(0, (i % 2) == 1, 1, (i % 3) != 0);
    // sweep 120 mode with chop patterns (R5, R6, R7)
    for (int i = 0; i < 72; i++) cyc(0, (i % 3) == 0, 1, (i % 4) < 2);
    // back to 180 mode at next wrap
    for (int i = 0; i < 60; i++) cyc(0, (i % 5) == 4, 0, (i % 7) != 3);
    // reset mid-run selecting 120 mode (R2)
    cyc(1, 1, 1, 1);
    cyc(1, 0, 1, 1);
    for (int i = 0; i < 40; i++) cyc(0, (i % 2) == 0, 1, 1);
    // reset back to 180 with gaps, chop active
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 60; i++) cyc(0, (i % 4) == 1, 0, (i % 2) == 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule